// File: doc/BRIEF.md
# Vectoring Interrupt Controller

This block sits between a set of interrupt sources and a small 8-bit processor that uses a request/acknowledge interrupt handshake. A rising edge on any source line sets that source's pending bit. When an unmasked source is pending and no delivery is under way, the controller raises its request to the processor. The processor answers with an acknowledge pulse, and the lowest-numbered eligible source is then locked in as the one being served.

The processor then fetches the interrupt instruction while it holds its interrupt-fetch level high. During that time the controller answers each memory read. In full-vector mode it returns three bytes: a subroutine-call opcode followed by that source's programmable 16-bit target, so the handler may sit at any address. In compact mode it returns a single restart opcode that selects one of eight fixed locations. The pending bit of the served source clears when its last byte has been read.

Software programs a mask bit per source, the delivery mode and one 16-bit vector per source through I/O port writes. The outgoing data bus is modelled as a data value plus an output-enable pin; a pad ring outside the block combines them into the shared bidirectional bus. The handshake is plain control signalling, so the block has no valid/ready stream interface and no back-pressure rules.

Top module: `vic_top`

## Requirements
- R1: After reset, int_req and bus_oe are 0, every mask bit is 0 (all sources enabled), the mode is full-vector, and every vector is 0x0000.
- R2: A 0-to-1 transition of src_irq[i], seen at a clock edge, sets pending bit i. int_req is high in the cycle after that edge when the source is unmasked and the controller is idle.
- R3: A masked pending source does not raise int_req. It stays pending, and clearing its mask bit raises int_req in the cycle after the write.
- R4: When an acknowledge is taken, the lowest-indexed pending unmasked source is chosen, and that choice holds until the delivery ends.
- R5: int_ack is taken only while int_req is high, and int_req is low from the cycle after an accepted acknowledge until the delivery completes or is abandoned. An int_ack while int_req is low has no effect.
- R6: In full-vector mode the delivery consists of three bytes in this order: 0xCD, then the low byte of the vector, then the high byte. The byte index advances when mem_rd falls while the controller is delivering with readint high.
- R7: In restart mode the delivery is one byte, 11nnn111 in binary, where nnn is the 3-bit index of the source.
- R8: bus_oe is 1 only while readint and mem_rd are both 1 and an accepted acknowledge is being served; otherwise the bus is not driven.
- R9: When the last byte's read ends, the served source's pending bit clears. Any other eligible pending source raises int_req again in the following cycle.
- R10: If readint falls before the last byte has been read, the delivery is abandoned. The source stays pending, int_req returns in the cycle after, and the next delivery starts again at the first byte.
- R11: The I/O write map is relative to IO_BASE. Offset 0 is the mask (bit i masks source i when 1). Offset 1 is the mode, where bit 0 set to 1 selects full-vector and 0 selects restart. Offsets 2+2i and 3+2i hold the low and high bytes of vector i. Writes to addresses outside this window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | N_SRC | Interrupt source lines; the rising edge is latched |
| cpu_addr | input | 16 | Processor address bus, decoded for I/O writes |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | Data bus value seen during I/O writes |
| mem_rd | input | 1 | Memory read strobe (level, one or more cycles) |
| readint | input | 1 | High for the whole interrupt instruction fetch |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| bus_dout | output | 8 | Instruction byte offered to the data bus |
| bus_oe | output | 1 | Data bus drive enable; 0 means high-impedance |

## Verification
The pending bit is registered and int_req is formed from it with no further register, so a source edge applied before a clock edge shows on int_req one cycle later. The same delay applies to a mask write and to a completed or abandoned delivery. bus_dout and bus_oe follow mem_rd in the same cycle, because they are combinational from the strobe and the registered byte index. The index advances one edge after mem_rd falls. The bench drives every input on the falling clock edge and samples either shortly after that edge or at the next falling edge, so every expected value lands on the cycle just counted.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FEED  = 2'd2
  } vic_state_e;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  function automatic logic [7:0] restart_byte(input logic [2:0] num);
    return {2'b11, num, 3'b111};
  endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int          N_SRC   = 8,
  parameter logic [15:0] IO_BASE = 16'h0040
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            cpu_addr,
  input  logic                   io_wr,
  input  logic [7:0]             io_wdata,
  output logic [N_SRC-1:0]       mask,
  output logic                   full_mode,
  output logic [N_SRC-1:0][15:0] vec
);

  localparam int NREG = 2 + 2 * N_SRC;

  logic [16:0] off;
  logic        hit;

  assign off = {1'b0, cpu_addr} - {1'b0, IO_BASE};
  assign hit = io_wr && (off < 17'(NREG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      full_mode <= 1'b1;
    end else if (hit) begin
      if (off == 17'd0) mask      <= io_wdata[N_SRC-1:0];
      if (off == 17'd1) full_mode <= io_wdata[0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec[i] <= '0;
      end else if (hit) begin
        if (off == 17'(2 + 2 * i)) vec[i][7:0]  <= io_wdata;
        if (off == 17'(3 + 2 * i)) vec[i][15:8] <= io_wdata;
      end
    end
  end

endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_irq,
  input  logic [N_SRC-1:0] mask,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             any_elig,
  output logic [IDX_W-1:0] win_idx
);

  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] elig;

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src_irq;
      pend  <= (pend & ~clr_vec) | (src_irq & ~src_q);
    end
  end

  assign elig     = pend & ~mask;
  assign any_elig = |elig;

  always_comb begin
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/vic_deliver.sv
module vic_deliver
  import vic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   full_mode,
  input  logic [N_SRC-1:0][15:0] vec,
  input  logic                   any_elig,
  input  logic [IDX_W-1:0]       win_idx,
  input  logic                   int_ack,
  input  logic                   readint,
  input  logic                   mem_rd,
  output logic                   int_req,
  output logic [7:0]             bus_dout,
  output logic                   bus_oe,
  output logic                   clr_en,
  output logic [IDX_W-1:0]       clr_idx,
  output vic_state_e             state,
  output logic [1:0]             cnt,
  output logic [IDX_W-1:0]       sel,
  output logic                   mode_q
);

  logic        rd_q;
  logic        rd_end;
  logic        last;
  logic [15:0] tgt;
  logic [2:0]  sel3;

  assign rd_end = rd_q && !mem_rd;
  assign last   = mode_q ? (cnt == 2'd2) : (cnt == 2'd0);
  assign tgt    = vec[sel];
  assign sel3   = 3'(sel);

  assign int_req = (state == ST_IDLE) && any_elig;
  assign clr_en  = (state == ST_FEED) && rd_end && last;
  assign clr_idx = sel;
  assign bus_oe  = (state != ST_IDLE) && readint && mem_rd;

  always_comb begin
    case (cnt)
      2'd0:    bus_dout = mode_q ? CALL_OPCODE : restart_byte(sel3);
      2'd1:    bus_dout = tgt[7:0];
      default: bus_dout = tgt[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sel    <= '0;
      mode_q <= 1'b1;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= mem_rd;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (int_ack && any_elig) begin
            state  <= ST_ARMED;
            sel    <= win_idx;
            mode_q <= full_mode;
          end
        end
        ST_ARMED: begin
          if (readint) state <= ST_FEED;
        end
        ST_FEED: begin
          if (rd_end) begin
            if (last) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 2'd1;
            end
          end else if (!readint) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int          N_SRC   = 8,
  parameter logic [15:0] IO_BASE = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_irq,
  input  logic [15:0]      cpu_addr,
  input  logic             io_wr,
  input  logic [7:0]       io_wdata,
  input  logic             mem_rd,
  input  logic             readint,
  input  logic             int_ack,
  output logic             int_req,
  output logic [7:0]       bus_dout,
  output logic             bus_oe
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]       mask;
  logic                   full_mode;
  logic [N_SRC-1:0][15:0] vec;
  logic                   any_elig;
  logic [IDX_W-1:0]       win_idx;
  logic                   clr_en;
  logic [IDX_W-1:0]       clr_idx;
  vic_state_e             state;
  logic [1:0]             cnt;
  logic [IDX_W-1:0]       sel;
  logic                   mode_q;

  vic_regs #(.N_SRC(N_SRC), .IO_BASE(IO_BASE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .mask     (mask),
    .full_mode(full_mode),
    .vec      (vec)
  );

  vic_pending #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_irq (src_irq),
    .mask    (mask),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .any_elig(any_elig),
    .win_idx (win_idx)
  );

  vic_deliver #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_dlv (
    .clk      (clk),
    .rst_n    (rst_n),
    .full_mode(full_mode),
    .vec      (vec),
    .any_elig (any_elig),
    .win_idx  (win_idx),
    .int_ack  (int_ack),
    .readint  (readint),
    .mem_rd   (mem_rd),
    .int_req  (int_req),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .state    (state),
    .cnt      (cnt),
    .sel      (sel),
    .mode_q   (mode_q)
  );

endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_req,
  input logic             int_ack,
  input logic             bus_oe,
  input logic             readint,
  input logic             mem_rd,
  input vic_state_e       state,
  input logic [1:0]       cnt,
  input logic [IDX_W-1:0] sel,
  input logic             mode_q
);

  // R8: drive only under both strobes
  p_oe_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (readint && mem_rd));

  // R5: accepted acknowledge withdraws the request
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> !int_req);

  // R6: byte index never beyond the third byte
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  // R7: restart delivery never leaves the first byte
  p_restart_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FEED && !mode_q) |-> (cnt == 2'd0));

  // R4: served source held during delivery
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(sel));

endmodule

bind vic_top vic_checker #(.IDX_W(IDX_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .int_req(int_req),
  .int_ack(int_ack),
  .bus_oe (bus_oe),
  .readint(readint),
  .mem_rd (mem_rd),
  .state  (state),
  .cnt    (cnt),
  .sel    (sel),
  .mode_q (mode_q)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;

  localparam int          N_SRC = 8;
  localparam logic [15:0] BASE  = 16'h0040;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_SRC-1:0] src_irq = '0;
  logic [15:0]      cpu_addr = '0;
  logic             io_wr = 1'b0;
  logic [7:0]       io_wdata = '0;
  logic             mem_rd = 1'b0;
  logic             readint = 1'b0;
  logic             int_ack = 1'b0;
  logic             int_req;
  logic [7:0]       bus_dout;
  logic             bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vic_top #(.N_SRC(N_SRC), .IO_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cpu_addr(cpu_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .mem_rd(mem_rd), .readint(readint),
    .int_ack(int_ack), .int_req(int_req), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_vec(input int i, input logic [15:0] v);
    io_write(BASE + 16'(2 + 2 * i), v[7:0]);
    io_write(BASE + 16'(3 + 2 * i), v[15:8]);
  endtask

  task automatic pulse_src(input logic [N_SRC-1:0] m);
    @(negedge clk);
    src_irq = m;
    @(negedge clk);
    src_irq = '0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    @(negedge clk);
    mem_rd = 1'b1;
    #1;
    check(bus_oe === 1'b1, "R8", bus_oe, 1);
    check(bus_dout === exp, req, bus_dout, exp);
    @(negedge clk);
    mem_rd = 1'b0;
    #1;
    check(bus_oe === 1'b0, "R8", bus_oe, 0);
    @(negedge clk);
  endtask

  task automatic deliver_call(input logic [15:0] v, input string req);
    ack();
    #1;
    check(int_req === 1'b0, "R5", int_req, 0);
    readint = 1'b1;
    @(negedge clk);
    read_byte(8'hCD, req);
    read_byte(v[7:0], req);
    read_byte(v[15:8], req);
    readint = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(int_req === 1'b0, "R1", int_req, 0);
    check(bus_oe === 1'b0, "R1", bus_oe, 0);
    pulse_src(8'h01);
    check(int_req === 1'b1, "R2", int_req, 1);
    deliver_call(16'h0000, "R1");
    @(negedge clk); #1;
    check(int_req === 1'b0, "R9", int_req, 0);
  endtask

  task automatic t_full();
    set_vec(2, 16'h1234);
    pulse_src(8'h04);
    check(int_req === 1'b1, "R2", int_req, 1);
    deliver_call(16'h1234, "R6");
    @(negedge clk); #1;
    check(int_req === 1'b0, "R9", int_req, 0);
  endtask

  task automatic t_priority();
    set_vec(3, 16'hA0B0);
    set_vec(5, 16'hC0D0);
    pulse_src(8'h28);
    deliver_call(16'hA0B0, "R4");
    @(negedge clk); #1;
    check(int_req === 1'b1, "R9", int_req, 1);
    deliver_call(16'hC0D0, "R4");
    @(negedge clk); #1;
    check(int_req === 1'b0, "R9", int_req, 0);
  endtask

  task automatic t_mask();
    set_vec(1, 16'hBEEF);
    io_write(BASE, 8'h02);
    pulse_src(8'h02);
    check(int_req === 1'b0, "R3", int_req, 0);
    io_write(BASE, 8'h00);
    #1;
    check(int_req === 1'b1, "R3", int_req, 1);
    deliver_call(16'hBEEF, "R3");
  endtask

  task automatic t_restart();
    io_write(BASE + 16'd1, 8'h00);
    pulse_src(8'h40);
    ack();
    readint = 1'b1;
    @(negedge clk);
    read_byte(8'hF7, "R7");
    readint = 1'b0;
    @(negedge clk); #1;
    check(int_req === 1'b0, "R7", int_req, 0);
    io_write(BASE + 16'd1, 8'h01);
  endtask

  task automatic t_abort();
    set_vec(4, 16'h5566);
    pulse_src(8'h10);
    ack();
    readint = 1'b1;
    @(negedge clk);
    read_byte(8'hCD, "R10");
    readint = 1'b0;
    @(negedge clk); #1;
    check(int_req === 1'b1, "R10", int_req, 1);
    deliver_call(16'h5566, "R10");
    @(negedge clk); #1;
    check(int_req === 1'b0, "R10", int_req, 0);
  endtask

  task automatic t_gate();
    @(negedge clk);
    readint = 1'b1; mem_rd = 1'b1;
    #1;
    check(bus_oe === 1'b0, "R8", bus_oe, 0);
    readint = 1'b0; mem_rd = 1'b0;
    ack();
    readint = 1'b1;
    @(negedge clk);
    mem_rd = 1'b1;
    #1;
    check(bus_oe === 1'b0, "R5", bus_oe, 0);
    @(negedge clk);
    mem_rd = 1'b0; readint = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_window();
    io_write(BASE + 16'd18, 8'hFF);
    io_write(BASE - 16'd1, 8'hFF);
    pulse_src(8'h80);
    check(int_req === 1'b1, "R11", int_req, 1);
    deliver_call(16'h0000, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_priority();
    t_mask();
    t_restart();
    t_abort();
    t_gate();
    t_window();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule